// File: doc/BRIEF.md
# Fractional-Rate Nanosecond Time-of-Day Counter

This block keeps a 64-bit nanosecond time-of-day value. It runs from a reference clock that is faster than the nominal tick rate. On every reference cycle a 32-bit rate word is added into a 32-bit phase accumulator. Each carry out of that accumulator is one nominal tick, and each tick adds a programmable nanosecond step to the time value.

The rate word sets the tick rate as a fraction of the reference rate. Its value is ceil(2^32 / R), where R is the reference frequency divided by the nominal frequency, and R is greater than 1. As an example, a rate word of 0x999999A4 with a 10 ns step matches a reference clock near 166.7 MHz. Software trims the rate in parts-per-billion steps by changing the rate word, and the accumulator phase is kept across the change. The usable trim is bounded by 1e9 × (R − 1) − 1 ppb.

A divider thins the tick stream into a slower output strobe. A divide value of 100 with 10 ns ticks gives a 1 MHz strobe. A 2-bit reference-source code is only stored: 0 is the external precision reference, 1 the system clock, 2 the transmit clock and 3 the real-time-clock input. Configuration goes through a plain single-cycle register port. That port has no streaming data, so it has no valid/ready handshake and no back-pressure.

Top module: `tod_clock_core`

## Requirements
- R1: After reset the rate word reads 0, the step reads 10, the divide value reads 0, the source code reads 1, the time value reads 0, and `tick_o` and `div_strobe_o` are low.
- R2: The accumulator starts at 0 and a rate word A is written at some edge. Over the N following clock edges, exactly floor(N·A / 2^32) ticks appear. Each tick is a one-cycle pulse on `tick_o` that is registered from the carry of the add at that edge.
- R3: A new rate word is first used by the add at the edge after the write. The accumulator is not cleared by the write, so the phase carries over.
- R4: Each tick adds the step register (address 1) to the time value.
- R5: A write to address 4 stages the low 32 bits of the time value. A write to address 5 loads {data, staged low} into the time value. A load takes priority over a tick at the same edge.
- R6: A read of address 4 returns the live low half and captures the high half. A read of address 5 returns the captured high half, so one pair of reads gives one consistent 64-bit value.
- R7: With a divide value D ≥ 2, `div_strobe_o` pulses on every D-th tick counted from reset, in the same cycle as that tick.
- R8: With a divide value of 0 or 1, `div_strobe_o` equals `tick_o`.
- R9: Address 3 stores `wr_data[1:0]` as the source code and ignores the upper bits. It reads back zero-extended.
- R10: Addresses 0, 1 and 2 read back the rate word, the step and the divide value as written. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; on address 4 it captures the high half |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Combinational read data |
| tick_o | output | 1 | One-cycle nominal tick pulse |
| div_strobe_o | output | 1 | Divided output strobe |

## Verification
Two situations are hard to reach from the ports.

The first is a high half that rolls over between the two halves of a read. To set it up, the bench freezes the accumulator with a zero rate word and loads a low half one step below a wrap. It reads the low half, then lets exactly one tick through by opening the rate word for two edges. The captured high half must then still show the old value.

The second is phase continuity. The bench parks the accumulator at half scale by writing a zero rate word on the very next edge. When the half-scale word returns, a tick must appear on the first add. A cleared accumulator would stay silent on that add.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_RATE  = 3'd0,
    A_STEP  = 3'd1,
    A_DIV   = 3'd2,
    A_SRC   = 3'd3,
    A_TLO   = 3'd4,
    A_THI   = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_EXT_PRECISE = 2'd0,
    SRC_SYSTEM      = 2'd1,
    SRC_TX          = 2'd2,
    SRC_RTC         = 2'd3
  } ref_src_e;
endpackage

// File: rtl/tod_cfg_regs.sv
module tod_cfg_regs
  import tod_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STEP_W   = 16,
  parameter int DIV_W    = 16,
  parameter int STEP_RST = 10,
  localparam int TIME_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rate_o,
  output logic [STEP_W-1:0] step_o,
  output logic [DIV_W-1:0]  div_o,
  output ref_src_e          src_o,
  output logic              load_o,
  output logic [TIME_W-1:0] load_val_o
);
  logic [DATA_W-1:0] lo_stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_o     <= '0;
      step_o     <= STEP_W'(STEP_RST);
      div_o      <= '0;
      src_o      <= SRC_SYSTEM;
      lo_stage_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_RATE: rate_o     <= wr_data;
        A_STEP: step_o     <= wr_data[STEP_W-1:0];
        A_DIV:  div_o      <= wr_data[DIV_W-1:0];
        A_SRC:  src_o      <= ref_src_e'(wr_data[1:0]);
        A_TLO:  lo_stage_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign load_o     = wr_en && (wr_addr == A_THI);
  assign load_val_o = {wr_data, lo_stage_q};

  assert_src_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SRC) |=> (src_o == $past(wr_data[1:0])));
  assert_rate_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_RATE) |=> (rate_o == $past(wr_data)));
endmodule

// File: rtl/tod_phase_acc.sv
module tod_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] rate_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] phase_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, phase_q} + {1'b0, rate_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      tick_o  <= 1'b0;
    end else begin
      phase_q <= sum[ACC_W-1:0];
      tick_o  <= sum[ACC_W];
    end
  end

  assert_zero_rate_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_i == '0) |=> !tick_o);
  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_i == '0) |=> $stable(phase_q));
endmodule

// File: rtl/tod_time_reg.sv
module tod_time_reg #(
  parameter int TIME_W = 64,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  output logic [TIME_W-1:0] time_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      time_o <= '0;
    else if (load_i) time_o <= load_val_i;
    else if (tick_i) time_o <= time_o + TIME_W'(step_i);
  end

  assert_step_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i) |=> (time_o == $past(time_o) + TIME_W'($past(step_i))));
  assert_load_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (time_o == $past(load_val_i)));
endmodule

// File: rtl/tod_divider.sv
module tod_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             strobe_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             bypass;
  logic             at_end;

  assign bypass   = (div_i <= DIV_W'(1));
  assign at_end   = (cnt_q >= div_i - DIV_W'(1));
  assign strobe_o = tick_i && (bypass || at_end);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (tick_i) begin
      if (bypass || at_end)  cnt_q <= '0;
      else                   cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assert_count_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !strobe_o) |=> (cnt_q == $past(cnt_q) + DIV_W'(1)));
  assert_count_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/tod_clock_core.sv
module tod_clock_core
  import tod_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STEP_W   = 16,
  parameter int DIV_W    = 16,
  parameter int STEP_RST = 10,
  localparam int TIME_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              tick_o,
  output logic              div_strobe_o
);
  logic [DATA_W-1:0] rate;
  logic [STEP_W-1:0] step;
  logic [DIV_W-1:0]  div;
  ref_src_e          src;
  logic              load;
  logic [TIME_W-1:0] load_val;
  logic [TIME_W-1:0] now;
  logic [DATA_W-1:0] hi_snap_q;

  tod_cfg_regs #(
    .DATA_W(DATA_W), .STEP_W(STEP_W), .DIV_W(DIV_W), .STEP_RST(STEP_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rate_o(rate), .step_o(step), .div_o(div), .src_o(src),
    .load_o(load), .load_val_o(load_val)
  );

  tod_phase_acc #(.ACC_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .rate_i(rate), .tick_o(tick_o)
  );

  tod_time_reg #(.TIME_W(TIME_W), .STEP_W(STEP_W)) u_time (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_o), .step_i(step),
    .load_i(load), .load_val_i(load_val), .time_o(now)
  );

  tod_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_o), .div_i(div), .strobe_o(div_strobe_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                           hi_snap_q <= '0;
    else if (rd_en && rd_addr == A_TLO)   hi_snap_q <= now[TIME_W-1:DATA_W];
  end

  always_comb begin
    case (rd_addr)
      A_RATE:  rd_data = rate;
      A_STEP:  rd_data = DATA_W'(step);
      A_DIV:   rd_data = DATA_W'(div);
      A_SRC:   rd_data = DATA_W'(src);
      A_TLO:   rd_data = now[DATA_W-1:0];
      A_THI:   rd_data = hi_snap_q;
      default: rd_data = '0;
    endcase
  end

  assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_TLO) |=> (hi_snap_q == $past(now[TIME_W-1:DATA_W])));
  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_addr == A_TLO) |=> $stable(hi_snap_q));
endmodule

// File: tb/tb_tod_clock_core.sv
module tb_tod_clock_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tick_o;
  logic        div_strobe_o;

  int n_chk = 0, n_fail = 0;
  int n_tick = 0, n_strb = 0, n_orphan = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tod_clock_core dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_o(tick_o), .div_strobe_o(div_strobe_o)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      n_tick = 0; n_strb = 0; n_orphan = 0;
    end else begin
      if (tick_o) n_tick++;
      if (div_strobe_o) n_strb++;
      if (div_strobe_o != tick_o && dut.u_div.div_i <= 1) n_orphan++;
      if (div_strobe_o && !tick_o) n_orphan++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(3'd0, d); chk("R1 rate", d, 0);
    rd(3'd1, d); chk("R1 step", d, 10);
    rd(3'd2, d); chk("R1 div", d, 0);
    rd(3'd3, d); chk("R1 src", d, 1);
    rd(3'd4, d); chk("R1 time lo", d, 0);
    rd(3'd5, d); chk("R1 time hi", d, 0);
    chk("R1 tick/strobe", {tick_o, div_strobe_o}, 0);
  endtask

  task automatic t_rate(input logic [31:0] a, input int n);
    longint unsigned exp;
    do_reset();
    wr(3'd0, a);
    cyc(n);
    exp = (longint'(n) * longint'(a)) >> 32;
    chk("R2 tick count", n_tick, exp);
  endtask

  task automatic t_phase();
    do_reset();
    wr(3'd0, 32'h8000_0000);
    wr(3'd0, 32'h0);
    chk("R3 no tick on first add", tick_o, 0);
    cyc(5);
    chk("R3 parked no tick", n_tick, 0);
    wr(3'd0, 32'h8000_0000);
    chk("R3 old word used at write edge", tick_o, 0);
    cyc(1);
    chk("R3 tick from kept phase", tick_o, 1);
  endtask

  task automatic t_step();
    logic [31:0] lo, hi;
    do_reset();
    wr(3'd1, 32'd7);
    wr(3'd0, 32'h4000_0000);
    cyc(20);
    wr(3'd0, 32'h0);
    cyc(3);
    chk("R4 tick count", n_tick, 5);
    rd(3'd4, lo); rd(3'd5, hi);
    chk("R4 time = ticks*step", {hi, lo}, 64'd35);
  endtask

  task automatic t_load_snap();
    logic [31:0] lo, hi;
    do_reset();
    wr(3'd4, 32'hFFFF_FFF6);
    wr(3'd5, 32'd5);
    rd(3'd4, lo);
    chk("R5 loaded lo", lo, 32'hFFFF_FFF6);
    wr(3'd0, 32'h8000_0000);
    cyc(1);
    wr(3'd0, 32'h0);
    cyc(3);
    chk("R6 one tick passed", n_tick, 1);
    rd(3'd5, hi);
    chk("R6 captured hi kept", hi, 5);
    rd(3'd4, lo); rd(3'd5, hi);
    chk("R5 rolled time", {hi, lo}, 64'h6_0000_0000);
  endtask

  task automatic t_div(input logic [31:0] dv, input int n, input int exp_strb);
    do_reset();
    wr(3'd2, dv);
    wr(3'd0, 32'h8000_0000);
    cyc(n);
    chk(dv >= 2 ? "R7 strobe count" : "R8 strobe count", n_strb, exp_strb);
    chk(dv >= 2 ? "R7 strobe with tick" : "R8 strobe equals tick", n_orphan, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    wr(3'd3, 32'd2);          rd(3'd3, d); chk("R9 src 2", d, 2);
    wr(3'd3, 32'hFFFF_FFFC);  rd(3'd3, d); chk("R9 upper ignored", d, 0);
    wr(3'd0, 32'h9999_99A4);  rd(3'd0, d); chk("R10 rate", d, 32'h9999_99A4);
    wr(3'd1, 32'd10);         rd(3'd1, d); chk("R10 step", d, 10);
    wr(3'd2, 32'd100);        rd(3'd2, d); chk("R10 div", d, 100);
    rd(3'd7, d); chk("R10 unmapped", d, 0);
  endtask

  initial begin
    t_reset();
    t_rate(32'h9999_99A4, 1000);
    t_rate(32'hFFFF_FFFF, 50);
    t_rate(32'h8000_0000, 20);
    t_phase();
    t_step();
    t_load_snap();
    t_div(32'd4, 80, 10);
    t_div(32'd1, 20, 10);
    t_div(32'd0, 20, 10);
    t_regs();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule